// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It moves each incoming frame into memory through a ring of two-word descriptors that software prepares. Word 0 of a descriptor holds a 4-byte-aligned buffer address, and its two low bits carry flags: an ownership bit and an end-of-ring marker. Word 1 gets the result of the transfer. When a frame starts, the block reads word 0 at the current ring position. It keeps the descriptor only if software has handed it over, which means the ownership bit is clear. It then stores the frame words into the buffer and writes back the length and an end-of-frame flag. Last, it marks the descriptor as consumed and moves to the next ring slot, or back to the ring base after a slot that carries the end-of-ring marker.

When the block reaches a descriptor that software has not yet returned, it discards the frame and raises two interrupt flags, one for the consumed descriptor and one for the lost data. The ring pointer stays where it is, so the next frame tries the same slot again. Interrupt flags remain set until software writes a 1 to them. All memory traffic goes through one simple request/acknowledge port that carries 32-bit words.

Top module: `rxd_ring_writer`

## Requirements
- R1: While `rx_en` is 0, arriving frames are accepted and dropped. There is no memory access and no interrupt flag changes. The ring pointer is reloaded from `ring_base`, so the first frame after enabling fetches the descriptor at `ring_base`.
- R2: For each frame received while enabled, the block first reads word 0 at the ring pointer. If bit 0 (the ownership bit) is 0, it claims the descriptor, and the buffer address is word 0 with bits 1:0 forced to 0.
- R3: Frame words are written to consecutive word addresses starting at the buffer address. The buffer holds `buf_units`×64 bytes, capped at 8188 bytes. Words beyond that capacity are accepted and dropped without any memory write.
- R4: After the last frame word, word 1 is written at pointer+4. Bits 12:0 hold the number of stored bytes: 4 for each stored word, except a final word that counts `in_last_bytes` bytes, with 0 meaning 4. Bit 15 is 1 (end of frame), and every other bit is 0.
- R5: After word 1, word 0 is written back at the pointer with bit 0 set and all other bits as they were fetched. It is the last write of the frame.
- R6: After that write-back, the ring pointer advances by 8. If bit 1 of the fetched word 0 was set, it returns to `ring_base` instead.
- R7: Completing a frame sets interrupt flag bit 1.
- R8: If the fetched word 0 has bit 0 set, the block sets interrupt flags bit 2 and bit 10 and drops the frame with no memory write. It does not advance the pointer, so the next frame fetches the same descriptor again.
- R9: Writing 1 to a bit of `irq_clr` clears that flag. Only bits 1, 2 and 10 can be set, and all other bits read 0. `irq_line` is high exactly when some flag is set.
- R10: Once `mem_req` is raised, it stays high with a stable address, direction and write data until `mem_ack`.
- R11: No frame word is accepted (`in_ready` is 0) while the block is idle or waiting for a descriptor fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Ring start address (8-byte aligned) |
| buf_units | input | 8 | Buffer size in 64-byte units |
| in_valid | input | 1 | Frame word valid |
| in_ready | output | 1 | Frame word accepted |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_last_bytes | input | 2 | Valid bytes in the last word, 0 means 4 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq_clr | input | 11 | Write-1-to-clear strobes |
| irq_status | output | 11 | Interrupt flags |
| irq_line | output | 1 | OR of all flags |

## Verification
The handshake checks assume the frame source keeps `in_valid`, `in_data` and `in_last` steady until a word is taken. They also assume that `rx_en`, `ring_base` and `buf_units` change only between frames. The bench drives one frame at a time from a task that holds each word until `in_ready`. It changes configuration only when the expected-write queue is empty. The memory model can withhold `mem_ack` at random, which stretches every transfer while keeping the request stable. Descriptor contents are edited by the bench only while no frame is in flight.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_DATA  = 3'd2,
      ST_WB1   = 3'd3,
      ST_WB0   = 3'd4,
      ST_DROP  = 3'd5
   } rxd_state_e;

   localparam int DESC_OWN_BIT  = 0;
   localparam int DESC_WRAP_BIT = 1;
   localparam int WB_EOF_BIT    = 15;

   localparam int IRQ_DONE_BIT  = 1;
   localparam int IRQ_USED_BIT  = 2;
   localparam int IRQ_OVR_BIT   = 10;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_base,
   input  logic          step,
   input  logic          wrap,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_base) begin
         ptr_q <= base;
      end else if (step) begin
         ptr_q <= wrap ? base : ptr_q + STRIDE;
      end
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/rxd_irq_flags.sv
module rxd_irq_flags #(
   parameter int                   NUM_IRQ   = 11,
   parameter logic [NUM_IRQ-1:0]   IMPL_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set,
   input  logic [NUM_IRQ-1:0] clr,
   output logic [NUM_IRQ-1:0] status,
   output logic               any
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_flop
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (set[i]) begin
               flag_q <= 1'b1;
            end else if (clr[i]) begin
               flag_q <= 1'b0;
            end
         end
         assign status[i] = flag_q;
      end else begin : g_tie
         logic unused_bit;
         assign unused_bit = set[i] ^ clr[i];
         assign status[i]  = 1'b0;
      end
   end

   assign any = |status;
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
   import rxd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LEN_W      = 13,
   parameter int UNIT_W     = 8,
   parameter int UNIT_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic [UNIT_W-1:0] buf_units,
   input  logic [AW-1:0]     ptr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DW-1:0]     in_data,
   input  logic              in_last,
   input  logic [1:0]        in_last_bytes,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   output logic              ptr_load,
   output logic              ptr_step,
   output logic              ptr_wrap,
   output logic              ev_done,
   output logic              ev_used,
   output rxd_state_e        st
);
   localparam int CNT_W   = LEN_W + 1;
   localparam int LEN_CAP = ((1 << LEN_W) - 1) & ~3;
   localparam int PROD_W  = UNIT_W + $clog2(UNIT_BYTES) + 1;
   localparam int WBYTES  = DW / 8;

   rxd_state_e      st_q, st_n;
   logic [DW-1:0]   desc_q;
   logic [CNT_W-1:0] off_q;
   logic [CNT_W-1:0] stored_q;

   logic [PROD_W-1:0] raw_cap;
   logic [CNT_W-1:0]  cap_b;
   logic [CNT_W:0]    off_next;
   logic              room;
   logic [CNT_W-1:0]  add_b;
   logic [AW-1:0]     buf_base;
   logic [DW-1:0]     wb1_word;
   logic              take;

   assign raw_cap  = PROD_W'(buf_units) * PROD_W'(UNIT_BYTES);
   assign cap_b    = (raw_cap > PROD_W'(LEN_CAP)) ? CNT_W'(LEN_CAP) : CNT_W'(raw_cap);
   assign off_next = {1'b0, off_q} + (CNT_W+1)'(WBYTES);
   assign room     = off_next <= {1'b0, cap_b};
   assign add_b    = (in_last && in_last_bytes != 2'd0) ? CNT_W'(in_last_bytes)
                                                        : CNT_W'(WBYTES);
   assign buf_base = {desc_q[AW-1:2], 2'b00};
   assign take     = in_valid && in_ready;

   always_comb begin
      wb1_word             = '0;
      wb1_word[LEN_W-1:0]  = stored_q[LEN_W-1:0];
      wb1_word[WB_EOF_BIT] = 1'b1;
   end

   always_comb begin
      st_n      = st_q;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      in_ready  = 1'b0;
      ptr_load  = 1'b0;
      ptr_step  = 1'b0;
      ev_done   = 1'b0;
      ev_used   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            ptr_load = !rx_en;
            if (in_valid) begin
               st_n = rx_en ? ST_FETCH : ST_DROP;
            end
         end
         ST_FETCH: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               if (mem_rdata[DESC_OWN_BIT]) begin
                  ev_used = 1'b1;
                  st_n    = ST_DROP;
               end else begin
                  st_n = ST_DATA;
               end
            end
         end
         ST_DATA: begin
            if (room) begin
               mem_req   = in_valid;
               mem_we    = 1'b1;
               mem_addr  = buf_base + AW'(off_q);
               mem_wdata = in_data;
               in_ready  = mem_ack;
            end else begin
               in_ready = 1'b1;
            end
            if (take && in_last) begin
               st_n = ST_WB1;
            end
         end
         ST_WB1: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr + AW'(WBYTES);
            mem_wdata = wb1_word;
            if (mem_ack) begin
               st_n = ST_WB0;
            end
         end
         ST_WB0: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr;
            mem_wdata = desc_q | DW'(1 << DESC_OWN_BIT);
            if (mem_ack) begin
               ptr_step = 1'b1;
               ev_done  = 1'b1;
               st_n     = ST_IDLE;
            end
         end
         ST_DROP: begin
            in_ready = 1'b1;
            if (in_valid && in_last) begin
               st_n = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         desc_q   <= '0;
         off_q    <= '0;
         stored_q <= '0;
      end else begin
         st_q <= st_n;
         if (st_q == ST_FETCH && mem_ack && !mem_rdata[DESC_OWN_BIT]) begin
            desc_q   <= mem_rdata;
            off_q    <= '0;
            stored_q <= '0;
         end else if (st_q == ST_DATA && take && room) begin
            off_q    <= off_next[CNT_W-1:0];
            stored_q <= stored_q + add_b;
         end
      end
   end

   assign ptr_wrap = desc_q[DESC_WRAP_BIT];
   assign st       = st_q;
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
   import rxd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LEN_W      = 13,
   parameter int UNIT_W     = 8,
   parameter int UNIT_BYTES = 64,
   parameter int NUM_IRQ    = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_en,
   input  logic [AW-1:0]      ring_base,
   input  logic [UNIT_W-1:0]  buf_units,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DW-1:0]      in_data,
   input  logic               in_last,
   input  logic [1:0]         in_last_bytes,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   input  logic               mem_ack,
   input  logic [DW-1:0]      mem_rdata,
   input  logic [NUM_IRQ-1:0] irq_clr,
   output logic [NUM_IRQ-1:0] irq_status,
   output logic               irq_line
);
   localparam int DESC_BYTES = 2 * (DW / 8);
   localparam logic [NUM_IRQ-1:0] IRQ_MASK =
      NUM_IRQ'((1 << IRQ_DONE_BIT) | (1 << IRQ_USED_BIT) | (1 << IRQ_OVR_BIT));

   if (DW != 32) begin : g_chk_dw
      $error("rxd_ring_writer: descriptor words must be 32 bits");
   end
   if (AW != DW) begin : g_chk_aw
      $error("rxd_ring_writer: address width must match word width");
   end
   if (LEN_W < 3 || LEN_W > WB_EOF_BIT - 2) begin : g_chk_len
      $error("rxd_ring_writer: length field must sit below the end-of-frame bit");
   end
   if (NUM_IRQ <= IRQ_OVR_BIT) begin : g_chk_irq
      $error("rxd_ring_writer: interrupt vector too narrow");
   end
   if ((UNIT_BYTES % 4) != 0) begin : g_chk_unit
      $error("rxd_ring_writer: buffer unit must be a whole number of words");
   end

   logic [AW-1:0]      ptr;
   logic               ptr_load, ptr_step, ptr_wrap;
   logic               ev_done, ev_used;
   logic [NUM_IRQ-1:0] irq_set;
   rxd_state_e         st;

   rxd_ring_ptr #(
      .AW         (AW),
      .DESC_BYTES (DESC_BYTES)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_base (ptr_load),
      .step      (ptr_step),
      .wrap      (ptr_wrap),
      .base      (ring_base),
      .ptr       (ptr)
   );

   rxd_seq #(
      .AW         (AW),
      .DW         (DW),
      .LEN_W      (LEN_W),
      .UNIT_W     (UNIT_W),
      .UNIT_BYTES (UNIT_BYTES)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_en         (rx_en),
      .buf_units     (buf_units),
      .ptr           (ptr),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_data       (in_data),
      .in_last       (in_last),
      .in_last_bytes (in_last_bytes),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata),
      .ptr_load      (ptr_load),
      .ptr_step      (ptr_step),
      .ptr_wrap      (ptr_wrap),
      .ev_done       (ev_done),
      .ev_used       (ev_used),
      .st            (st)
   );

   always_comb begin
      irq_set               = '0;
      irq_set[IRQ_DONE_BIT] = ev_done;
      irq_set[IRQ_USED_BIT] = ev_used;
      irq_set[IRQ_OVR_BIT]  = ev_used;
   end

   rxd_irq_flags #(
      .NUM_IRQ   (NUM_IRQ),
      .IMPL_MASK (IRQ_MASK)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (irq_set),
      .clr    (irq_clr),
      .status (irq_status),
      .any    (irq_line)
   );
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk
   import rxd_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int NUM_IRQ = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_en,
   input logic               in_valid,
   input logic               in_ready,
   input logic               mem_req,
   input logic               mem_we,
   input logic [AW-1:0]      mem_addr,
   input logic [DW-1:0]      mem_wdata,
   input logic               mem_ack,
   input logic [DW-1:0]      mem_rdata,
   input logic [NUM_IRQ-1:0] irq_clr,
   input logic [NUM_IRQ-1:0] irq_status,
   input logic               irq_line,
   input rxd_state_e         st
);
   localparam logic [NUM_IRQ-1:0] LIVE =
      NUM_IRQ'((1 << IRQ_DONE_BIT) | (1 << IRQ_USED_BIT) | (1 << IRQ_OVR_BIT));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R11
   no_early_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_FETCH) |-> !in_ready);

   // R8
   used_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH && mem_ack && mem_rdata[DESC_OWN_BIT])
      |=> (irq_status[IRQ_USED_BIT] && irq_status[IRQ_OVR_BIT]));

   // R8
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DROP) |-> !mem_req);

   // R7
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WB0 && mem_ack) |=> irq_status[IRQ_DONE_BIT]);

   // R4
   eof_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WB1 && mem_req) |-> (mem_we && mem_wdata[WB_EOF_BIT]
                                     && mem_wdata[14:13] == 2'b00
                                     && mem_wdata[DW-1:16] == '0));

   // R5
   own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WB1 && mem_ack) |=> (st == ST_WB0 && mem_wdata[DESC_OWN_BIT]));

   // R1
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !rx_en && in_valid) |=> (st == ST_DROP));

   // R9
   dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status & ~LIVE) == '0);

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[IRQ_DONE_BIT] && irq_clr[IRQ_DONE_BIT] && !(st == ST_WB0 && mem_ack))
      |=> !irq_status[IRQ_DONE_BIT]);

   // R9
   line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line == (irq_status != '0));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(
   .AW      (AW),
   .DW      (DW),
   .NUM_IRQ (NUM_IRQ)
) u_chk (.*);

// File: tb/rxd_ring_writer_test.sv
module rxd_ring_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [31:0] ring_base = 32'h100;
   logic [7:0]  buf_units = 8'd2;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic [1:0]  in_last_bytes = '0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [10:0] irq_clr = '0;
   logic [10:0] irq_status;
   logic        irq_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxd_ring_writer uut (
      .clk (clk), .rst_n (rst_n), .rx_en (rx_en), .ring_base (ring_base),
      .buf_units (buf_units), .in_valid (in_valid), .in_ready (in_ready),
      .in_data (in_data), .in_last (in_last), .in_last_bytes (in_last_bytes),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
      .irq_clr (irq_clr), .irq_status (irq_status), .irq_line (irq_line)
   );

   // memory model
   logic [31:0] mem [0:MEM_WORDS-1];
   logic        stall = 1'b0;
   logic        stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   assign mem_rdata = mem[mem_addr[11:2]];
   assign mem_ack   = mem_req && !stall;

   always @(posedge clk) begin
      lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall <= stall_en && lfsr[0];
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference expectations
   logic [31:0] exp_addr[$];
   logic [31:0] exp_data[$];
   string       exp_tag[$];
   int          exp_fetch = -1;
   int          m_ptr;
   logic [10:0] m_irq = '0;

   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (mem_we) begin
            if (exp_addr.size() == 0) begin
               chk(1'b0, "R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
            end else begin
               chk(mem_addr == exp_addr[0], {exp_tag[0], " addr"}, mem_addr, exp_addr[0]);
               chk(mem_wdata == exp_data[0], {exp_tag[0], " data"}, mem_wdata, exp_data[0]);
               void'(exp_addr.pop_front());
               void'(exp_data.pop_front());
               void'(exp_tag.pop_front());
            end
            mem[mem_addr[11:2]] = mem_wdata;
         end else begin
            chk(exp_fetch >= 0 && mem_addr == exp_fetch, "R2 R6 fetch address",
                mem_addr, exp_fetch);
            exp_fetch = -1;
         end
      end
   end

   function automatic int cap_bytes();
      int c = int'(buf_units) * 64;
      return (c > 8188) ? 8188 : c;
   endfunction

   task automatic send_frame(input int nw, input logic [1:0] lb, input logic [7:0] id);
      logic [31:0] w0;
      int          stored = 0;
      int          cap;
      if (rx_en) begin
         exp_fetch = m_ptr;
         w0 = mem[m_ptr[11:2]];
         if (w0[0]) begin
            m_irq[2]  = 1'b1;    // R8
            m_irq[10] = 1'b1;
         end else begin
            cap = cap_bytes();
            for (int i = 0; i < nw; i++) begin
               if (4*i + 4 <= cap) begin
                  exp_addr.push_back({w0[31:2], 2'b00} + 32'(4*i));
                  exp_data.push_back({id, 8'h5A, 16'(i)});
                  exp_tag.push_back("R2 R3 buffer write");
                  stored += (i == nw-1 && lb != 0) ? int'(lb) : 4;
               end
            end
            exp_addr.push_back(32'(m_ptr + 4));
            exp_data.push_back(32'h8000 | 32'(stored));
            exp_tag.push_back("R4 length word");
            exp_addr.push_back(32'(m_ptr));
            exp_data.push_back(w0 | 32'h1);
            exp_tag.push_back("R5 ownership write");
            m_irq[1] = 1'b1;     // R7
            m_ptr = w0[1] ? int'(ring_base) : m_ptr + 8;   // R6
         end
      end
      for (int i = 0; i < nw; i++) begin
         bit acc;
         @(negedge clk);
         in_valid      = 1'b1;
         in_data       = {id, 8'h5A, 16'(i)};
         in_last       = (i == nw-1);
         in_last_bytes = (i == nw-1) ? lb : 2'd0;
         forever begin
            #1 acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      while (exp_addr.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_addr.size() == 0 && exp_fetch == -1, "R3 R8 pending traffic",
          32'(exp_addr.size()), 32'd0);
      exp_fetch = -1;
   endtask

   task automatic check_irq(input string req);
      @(negedge clk);
      chk(irq_status == m_irq, req, 32'(irq_status), 32'(m_irq));
      chk(irq_line == (m_irq != 0), "R9 irq line", 32'(irq_line), 32'(m_irq != 0));
   endtask

   task automatic clear_irq(input logic [10:0] v);
      @(negedge clk);
      irq_clr = v;
      @(negedge clk);
      irq_clr = '0;
      m_irq = m_irq & ~v;
      check_irq("R9 write-one clear");
   endtask

   bit finished = 1'b0;

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         chk(1'b0, "watchdog", 32'd0, 32'd1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      // ring at 0x100: three slots, last one wraps
      mem[32'h100 >> 2] = 32'h0000_0400;
      mem[32'h104 >> 2] = 32'hFFFF_FFFF;
      mem[32'h108 >> 2] = 32'h0000_0600;
      mem[32'h10C >> 2] = 32'hFFFF_FFFF;
      mem[32'h110 >> 2] = 32'h0000_0802;   // wrap marker
      mem[32'h114 >> 2] = 32'hFFFF_FFFF;
      // second ring at 0x180
      mem[32'h180 >> 2] = 32'h0000_0A02;
      mem[32'h184 >> 2] = 32'h0;
      m_ptr = 32'h100;

      repeat (3) @(negedge clk);
      // reset state
      chk(irq_status == 0, "R9 reset flags", 32'(irq_status), 32'd0);
      chk(!mem_req, "R10 reset request", 32'(mem_req), 32'd0);
      chk(!in_ready, "R11 reset ready", 32'(in_ready), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: disabled, frame dropped with no traffic
      send_frame(3, 2'd0, 8'h01);
      check_irq("R1 disabled frame leaves flags");

      rx_en = 1'b1;
      @(negedge clk);
      #1 chk(!in_ready, "R11 idle ready low", 32'(in_ready), 32'd0);

      // R2 R3 R4: 5 words, 2 bytes in last => 18
      send_frame(5, 2'd2, 8'h02);
      check_irq("R7 completion flag");
      clear_irq(11'h002);

      // R4: single word with 1 byte
      stall_en = 1'b1;
      send_frame(1, 2'd1, 8'h03);
      check_irq("R7 completion flag again");

      // R3: oversize frame truncated at 128 bytes, wrap slot (R6)
      send_frame(40, 2'd0, 8'h04);
      check_irq("R7 after truncated frame");
      clear_irq(11'h002);

      // R8: slot 0 still owned by hardware side -> drop
      send_frame(4, 2'd3, 8'h05);
      check_irq("R8 used descriptor flags");
      clear_irq(11'h404);

      // R8: refetch same slot after software returns it
      mem[32'h100 >> 2] = 32'h0000_0401;   // low bit set -> still used
      mem[32'h100 >> 2] = 32'h0000_0400;
      send_frame(2, 2'd3, 8'h06);
      check_irq("R8 retry completes");
      clear_irq(11'h7FF);

      // R1: disable, move the base, re-enable
      rx_en = 1'b0;
      ring_base = 32'h180;
      repeat (3) @(negedge clk);
      rx_en = 1'b1;
      m_ptr = 32'h180;
      send_frame(3, 2'd0, 8'h07);
      check_irq("R1 new base frame");
      // R6: wrap to base 0x180 again; that slot is now used -> R8
      send_frame(2, 2'd0, 8'h08);
      check_irq("R6 R8 wrap onto used slot");

      // R3: zero-size buffer stores nothing
      clear_irq(11'h7FF);
      mem[32'h180 >> 2] = 32'h0000_0A02;
      buf_units = 8'd0;
      send_frame(2, 2'd0, 8'h09);
      check_irq("R3 R7 empty buffer frame");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule